// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is one voice of a sound generator: it turns a 15-bit linear feedback shift register into a stream of 4-bit noise samples. Software programs it through four byte-wide registers. These set the play length, the volume envelope, the shift rate and sequence width, and the trigger with its length-limit switch. A write with the trigger bit set starts the noise from a known state.

The shift rate is derived from a unit tick that runs at twice the base frequency. A 3-bit ratio code and a 4-bit power-of-two code scale it down. Two slow strobes from a shared frame sequencer advance the length counter and the envelope. Mixing and output routing happen elsewhere.

Top module: `noise_voice`

## Requirements
- R1: Writes use addresses 0 (length, bits 5-0), 1 (envelope), 2 (polynomial) and 3 (control). Reading address 3 returns bit 6 as the length-limit enable, with every other bit at 1. Reading address 0 returns 0xFF. Reading addresses 1 and 2 returns the last value written.
- R2: The shift period in unit ticks is B * 2^(s+1). Here s is polynomial bits 7-4 and r is bits 2-0. B is 1 when r = 0 and 2*r otherwise. The first shift after a trigger happens on the period-th unit tick.
- R3: Each shift moves the register right by one and puts bit0 XOR bit1 into bit 14. When polynomial bit 3 is 1 (short mode), the same value is also written into bit 6.
- R4: A control write with bit 7 set does four things: it sets the register to all ones, reloads the level from envelope bits 7-4, reloads the envelope and shift timers, and makes the voice active.
- R5: The sample equals the current level when the voice is active and register bit 0 is 0. Otherwise the sample is 0.
- R6: With shift codes 14 and 15 the register never advances.
- R7: Envelope bits 2-0 give a step period counted in envelope ticks, and 0 disables stepping. Bit 3 set counts the level up, with a ceiling of 15. Bit 3 clear counts it down, with a floor of 0.
- R8: A length write L loads a count of 64-L. With control bit 6 set, each length tick lowers the count, and the voice goes inactive when the count reaches 0. A trigger that finds the count at 0 reloads it with 64. With bit 6 clear, length ticks have no effect.
- R9: After reset the voice is inactive, the sample and level are 0, and the control register reads 0xBF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data |
| unit_tick | input | 1 | Shift-rate unit strobe (twice the base frequency) |
| len_tick | input | 1 | Length counter strobe from the frame sequencer |
| env_tick | input | 1 | Envelope strobe from the frame sequencer |
| active | output | 1 | Voice is playing |
| level | output | 4 | Current envelope level |
| sample | output | 4 | Noise sample |

## Verification
On every cycle, the assertions check several properties. A trigger must leave the register all ones with the voice active. Codes 14 and 15 must keep the register frozen. Short mode must mirror the feedback into bit 6. The level may move by at most one step between triggers. The voice may only drop out on a length tick. Some properties need the bench's scenarios and its reference register model. These are the exact shift period for each ratio and shift code, the full sample sequence in both widths, envelope step periods and limits, and the length count with its reload.

// File: rtl/noise_voice.sv
`timescale 1ns/1ps
module noise_voice #(
  parameter int LFSR_W = 15,
  parameter int VOL_W  = 4,
  parameter int LEN_W  = 6,
  parameter int TMR_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             unit_tick,
  input  logic             len_tick,
  input  logic             env_tick,
  output logic             active,
  output logic [VOL_W-1:0] level,
  output logic [VOL_W-1:0] sample
);
  localparam int LEN_CW = LEN_W + 1;
  localparam logic [LEN_CW-1:0] LEN_FULL = LEN_CW'(1 << LEN_W);
  localparam logic [VOL_W-1:0]  VOL_MAX  = '1;

  logic [7:0]        env_reg, poly_reg;
  logic              len_en;
  logic [LFSR_W-1:0] lfsr;
  logic [LEN_CW-1:0] len_cnt;
  logic [2:0]        env_cnt;
  logic [TMR_W-1:0]  tmr;

  wire trig     = wr_en && wr_addr == 2'd3 && wr_data[7];
  wire [3:0] shf = poly_reg[7:4];
  wire [2:0] rat = poly_reg[2:0];
  wire short_md = poly_reg[3];
  wire frozen   = shf >= 4'd14;

  wire [TMR_W-1:0] base   = (rat == 3'd0) ? TMR_W'(1) : TMR_W'({rat, 1'b0});
  wire [TMR_W-1:0] period = base << (shf + 4'd1);

  wire fb = lfsr[0] ^ lfsr[1];
  logic [LFSR_W-1:0] lfsr_nxt;
  always_comb begin
    lfsr_nxt = {fb, lfsr[LFSR_W-1:1]};
    if (short_md) lfsr_nxt[6] = fb;
  end

  wire tmr_hit = active && unit_tick && tmr == '0;
  wire do_shift = tmr_hit && !frozen && !trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      env_reg  <= '0;
      poly_reg <= '0;
      len_en   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd1: env_reg  <= wr_data;
        2'd2: poly_reg <= wr_data;
        2'd3: len_en   <= wr_data[6];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= '1;
      tmr  <= '0;
    end else if (trig) begin
      lfsr <= '1;
      tmr  <= period - TMR_W'(1);
    end else if (active && unit_tick) begin
      if (tmr == '0) begin
        tmr <= period - TMR_W'(1);
        if (!frozen) lfsr <= lfsr_nxt;
      end else begin
        tmr <= tmr - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      len_cnt <= '0;
    end else if (trig) begin
      active <= 1'b1;
      if (len_cnt == '0) len_cnt <= LEN_FULL;
    end else if (wr_en && wr_addr == 2'd0) begin
      len_cnt <= LEN_FULL - LEN_CW'(wr_data[LEN_W-1:0]);
    end else if (len_tick && len_en && len_cnt != '0) begin
      len_cnt <= len_cnt - LEN_CW'(1);
      if (len_cnt == LEN_CW'(1)) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= '0;
      env_cnt <= '0;
    end else if (trig) begin
      level   <= env_reg[7:4];
      env_cnt <= env_reg[2:0];
    end else if (env_tick && env_reg[2:0] != 3'd0) begin
      if (env_cnt <= 3'd1) begin
        env_cnt <= env_reg[2:0];
        if (env_reg[3] && level != VOL_MAX) level <= level + VOL_W'(1);
        else if (!env_reg[3] && level != '0) level <= level - VOL_W'(1);
      end else begin
        env_cnt <= env_cnt - 3'd1;
      end
    end
  end

  assign sample = (active && !lfsr[0]) ? level : '0;

  always_comb begin
    case (rd_addr)
      2'd1:    rd_data = env_reg;
      2'd2:    rd_data = poly_reg;
      2'd3:    rd_data = {1'b1, len_en, 6'h3F};
      default: rd_data = 8'hFF;
    endcase
  end

  a_r4_trigger_state: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (lfsr == '1 && active));
  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_en) |=> $stable(lfsr));
  a_r3_short_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (do_shift && short_md) |=> lfsr[6] == lfsr[LFSR_W-1]);
  a_r7_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> (level == $past(level) || level == $past(level) + VOL_W'(1)
               || level == $past(level) - VOL_W'(1)));
  a_r8_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !len_tick) |=> active);
endmodule

// File: tb/noise_voice_tb.sv
`timescale 1ns/1ps
module noise_voice_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic unit_tick = 0, len_tick = 0, env_tick = 0;
  logic active;
  logic [3:0] level, sample;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  noise_voice u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .unit_tick(unit_tick),
    .len_tick(len_tick), .env_tick(env_tick), .active(active), .level(level),
    .sample(sample));

  localparam int NV = 8;
  localparam logic [7:0] V_POLY [NV] = '{8'h00, 8'h08, 8'h01, 8'h13, 8'h2A, 8'hE0, 8'hF5, 8'h07};
  localparam int V_GAP [NV] = '{0, 0, 0, 2, 0, 0, 0, 1};
  localparam int V_LEN [NV] = '{300, 300, 200, 400, 400, 200, 200, 300};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pulse_len();
    @(negedge clk); len_tick = 1; @(posedge clk); #1; len_tick = 0;
  endtask

  task automatic pulse_env();
    @(negedge clk); env_tick = 1; @(posedge clk); #1; env_tick = 0;
  endtask

  function automatic int per_of(input logic [7:0] p);
    int b = (p[2:0] == 0) ? 1 : 2 * p[2:0];
    return b << (p[7:4] + 1);
  endfunction

  task automatic run_vec(input int k);
    logic [14:0] m = '1;
    int cnt = 0, bad = 0, first_bad_a = 0, first_bad_e = 0;
    int per = per_of(V_POLY[k]);
    logic fbit;
    wr(2'd1, 8'hF0);
    wr(2'd2, V_POLY[k]);
    wr(2'd3, 8'h80);
    for (int i = 0; i < V_LEN[k]; i++) begin
      @(negedge clk);
      unit_tick = (i % (V_GAP[k] + 1)) == 0;
      @(posedge clk); #1;
      if (unit_tick) begin
        cnt++;
        if (cnt == per) begin
          cnt = 0;
          if (V_POLY[k][7:4] < 4'd14) begin
            fbit = m[0] ^ m[1];
            m = {fbit, m[14:1]};
            if (V_POLY[k][3]) m[6] = fbit;
          end
        end
      end
      if (sample != (m[0] ? 4'd0 : 4'd15) && bad == 0) begin
        first_bad_a = sample; first_bad_e = m[0] ? 0 : 15;
      end
      if (sample != (m[0] ? 4'd0 : 4'd15)) bad++;
    end
    unit_tick = 0;
    if (bad != 0) chk("R2/R3/R5/R6 sample stream", first_bad_a, first_bad_e);
    else chk("R2/R3/R5/R6 sample stream", 0, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_addr = 2'd3; #1;
    chk("R9 active", active, 0);
    chk("R9 sample", sample, 0);
    chk("R9 level", level, 0);
    chk("R9 ctrl read", rd_data, 8'hBF);

    for (int k = 0; k < NV; k++) run_vec(k);

    wr(2'd3, 8'h40); rd_addr = 2'd3; #1;
    chk("R1 ctrl read len_en", rd_data, 8'hFF);
    rd_addr = 2'd0; #1;
    chk("R1 length read", rd_data, 8'hFF);
    wr(2'd2, 8'h5B); rd_addr = 2'd2; #1;
    chk("R1 poly read", rd_data, 8'h5B);
    wr(2'd3, 8'h00); rd_addr = 2'd3; #1;
    chk("R1 ctrl read cleared", rd_data, 8'hBF);

    wr(2'd1, 8'h21); wr(2'd3, 8'h80);
    chk("R4 level reload", level, 2);
    chk("R4 active", active, 1);
    chk("R5 sample after trigger", sample, 0);
    pulse_env(); chk("R7 down step", level, 1);
    pulse_env(); chk("R7 down step", level, 0);
    pulse_env(); chk("R7 floor", level, 0);
    wr(2'd1, 8'hE9); wr(2'd3, 8'h80);
    pulse_env(); chk("R7 up step", level, 15);
    pulse_env(); chk("R7 ceiling", level, 15);
    wr(2'd1, 8'hA2); wr(2'd3, 8'h80);
    pulse_env(); chk("R7 period 2 hold", level, 10);
    pulse_env(); chk("R7 period 2 step", level, 9);
    wr(2'd1, 8'h70); wr(2'd3, 8'h80);
    pulse_env(); chk("R7 period 0 no step", level, 7);

    wr(2'd0, 8'd62); wr(2'd3, 8'hC0);
    pulse_len(); chk("R8 still active", active, 1);
    pulse_len(); chk("R8 expired", active, 0);
    chk("R5 sample inactive", sample, 0);
    wr(2'd3, 8'h80);
    for (int i = 0; i < 70; i++) pulse_len();
    chk("R8 no effect when disabled", active, 1);
    wr(2'd3, 8'hC0);
    for (int i = 0; i < 63; i++) pulse_len();
    chk("R8 reload 64 before end", active, 1);
    pulse_len(); chk("R8 reload 64 end", active, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule